// File: doc/BRIEF.md
# Vector Micro-Op Sequencer

This block takes one vector instruction at a time and breaks it into a run of micro-ops, one per cycle, each covering one vector register's worth of elements. Along with the instruction comes its vector configuration: active length, maximum length, element width code and a tail-agnostic bit. It also carries up to four source register numbers and one destination register number. Each micro-op leaves with its register numbers stepped according to a sequencing mode, a 0-based index, a tail flag and a last flag.

There are five sequencing modes: plain arithmetic, single-destination (reductions and compares), widening, multiply-accumulate and widening multiply-accumulate. Both sides use valid/ready handshakes. A flush input drops the sequence in progress. An illegal offer produces a one-cycle error pulse and no micro-ops. A saturating counter reports how many micro-ops have left the block.

Top module: `vuop_seq`

## Requirements
- R1: The element width code `in_sew` selects 8, 16, 32 or 64 bits for codes 0 to 3, and a micro-op holds EPU = VREG_BYTES >> in_sew elements. An instruction yields ceil(in_vlmax / EPU) micro-ops whether or not elements fall in the tail. They carry `out_idx` 0, 1, 2 and so on, and `out_last` is high on the final one only.
- R2: The widening modes (code 3 widen, code 5 widening accumulate) produce twice the R1 count.
- R3: In arithmetic mode (code 1) and accumulate mode (code 4), the destination and every used source slot are offset by the micro-op index, modulo 32. Source slot k sits at bits [5k+4:5k] of the packed source bus, and unused slots read zero.
- R4: In the widening modes the destination is offset by the index. The sources are offset by the index rounded down to even, so micro-ops 0 to 3 read sources at +0, +0, +2, +2.
- R5: In single-destination mode (code 2) the destination number is not changed, while the sources advance by the index.
- R6: In the accumulate modes (codes 4 and 5) the stepped destination is also placed in source slot `in_src_cnt`, and `out_src_cnt` is one higher than `in_src_cnt`. In the other modes `out_src_cnt` equals `in_src_cnt`.
- R7: `out_tail` is high when EPU × (index + 1) is greater than `in_vl`.
- R8: `in_ready` is high only when no sequence is in progress and no flush is present. A micro-op that is not taken stays unchanged. After the final micro-op is taken the block returns to idle.
- R9: An accepted offer is illegal if its mode code is 0, 6 or 7, if its count is zero, if `in_src_cnt` is above 4, or if it is an accumulate mode with `in_src_cnt` of 4. An illegal offer makes `err` high for exactly the next cycle and produces no micro-ops.
- R10: While `flush` is high, `out_valid` and `in_ready` are low and nothing is accepted. The sequence in progress ends, and no further micro-op of it appears.
- R11: `uop_count` goes up by one for each micro-op taken and holds at its all-ones value.
- R12: Every micro-op carries the instruction's tail-agnostic bit on `out_ta`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Drop the sequence in progress |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Sequencer idle and able to accept |
| in_mode | input | 3 | Sequencing mode code |
| in_sew | input | 2 | Element width code |
| in_vl | input | VL_W | Active vector length |
| in_vlmax | input | VL_W | Maximum vector length |
| in_ta | input | 1 | Tail-agnostic bit |
| in_src_cnt | input | 3 | Number of sources used |
| in_srcs | input | 20 | Packed source register numbers, 5 bits per slot |
| in_dst | input | 5 | Destination register number |
| out_valid | output | 1 | Micro-op present |
| out_ready | input | 1 | Micro-op taken |
| out_idx | output | VL_W+2 | Micro-op index |
| out_srcs | output | 20 | Stepped packed sources |
| out_src_cnt | output | 3 | Number of sources in the micro-op |
| out_dst | output | 5 | Stepped destination |
| out_tail | output | 1 | Micro-op covers tail elements |
| out_ta | output | 1 | Tail-agnostic bit |
| out_last | output | 1 | Final micro-op of the instruction |
| err | output | 1 | Illegal offer seen in the previous cycle |
| uop_count | output | CNT_W | Saturating count of micro-ops taken |

## Verification
A bad index register shows up on the very next micro-op as a wrong `out_idx`, wrong stepped registers or a misplaced `out_last`. A bad count shows as a sequence that ends early or runs late, which is seen at the end of that instruction. A busy flag that does not clear on flush or after the last micro-op is caught in the next cycle: `out_valid` stays high, or `in_ready` stays low. Counter faults show the cycle after a micro-op is taken, and saturation is tested by building the counter narrow enough to wrap within one run.

// File: rtl/vuop_pkg.sv
package vuop_pkg;
    localparam int REG_W     = 5;
    localparam int MAX_SRC   = 4;
    localparam int SRC_CNT_W = 3;
    localparam int ELOG_W    = 3;

    typedef enum logic [2:0] {
        SEQ_NONE     = 3'd0,
        SEQ_ARITH    = 3'd1,
        SEQ_ONE_DST  = 3'd2,
        SEQ_WIDE     = 3'd3,
        SEQ_MAC      = 3'd4,
        SEQ_MAC_WIDE = 3'd5
    } seq_mode_e;

    typedef struct packed {
        logic [MAX_SRC*REG_W-1:0] srcs;
        logic [SRC_CNT_W-1:0]     src_cnt;
        logic [REG_W-1:0]         dst;
    } uop_ops_t;

    function automatic logic mode_legal(logic [2:0] m);
        return (m >= SEQ_ARITH) && (m <= SEQ_MAC_WIDE);
    endfunction

    function automatic logic mode_wide(logic [2:0] m);
        return (m == SEQ_WIDE) || (m == SEQ_MAC_WIDE);
    endfunction

    function automatic logic mode_mac(logic [2:0] m);
        return (m == SEQ_MAC) || (m == SEQ_MAC_WIDE);
    endfunction
endpackage

// File: rtl/vuop_plan.sv
module vuop_plan
    import vuop_pkg::*;
#(
    parameter int VREG_BYTES = 16,
    parameter int VL_W       = 8,
    localparam int UIDX_W    = VL_W + 2,
    localparam int LOG_EPU0  = $clog2(VREG_BYTES)
) (
    input  logic [2:0]           mode,
    input  logic [1:0]           sew,
    input  logic [VL_W-1:0]      vlmax,
    input  logic [SRC_CNT_W-1:0] src_cnt,
    output logic [ELOG_W-1:0]    elog,
    output logic [UIDX_W-1:0]    total,
    output logic                 bad
);
    logic [UIDX_W-1:0] rounded;
    logic [UIDX_W-1:0] base;

    always_comb begin
        elog    = ELOG_W'(LOG_EPU0 - int'(sew));
        rounded = UIDX_W'(vlmax) + (UIDX_W'(1) << elog) - UIDX_W'(1);
        base    = rounded >> elog;
        total   = mode_wide(mode) ? (base << 1) : base;
        bad     = !mode_legal(mode) || (base == '0)
                  || (src_cnt > SRC_CNT_W'(MAX_SRC))
                  || (mode_mac(mode) && (src_cnt >= SRC_CNT_W'(MAX_SRC)));
    end
endmodule

// File: rtl/vuop_operands.sv
module vuop_operands
    import vuop_pkg::*;
(
    input  logic [2:0]               mode,
    input  logic [REG_W-1:0]         idx_lo,
    input  logic [MAX_SRC*REG_W-1:0] srcs_i,
    input  logic [SRC_CNT_W-1:0]     cnt_i,
    input  logic [REG_W-1:0]         dst_i,
    output uop_ops_t                 ops_o
);
    logic [REG_W-1:0] soff;
    logic [REG_W-1:0] dst_step;
    logic             mac;

    always_comb begin
        mac      = mode_mac(mode);
        soff     = mode_wide(mode) ? {idx_lo[REG_W-1:1], 1'b0} : idx_lo;
        dst_step = (mode == SEQ_ONE_DST) ? dst_i : dst_i + idx_lo;
    end

    for (genvar k = 0; k < MAX_SRC; k++) begin : g_slot
        always_comb begin
            if (SRC_CNT_W'(k) < cnt_i)
                ops_o.srcs[k*REG_W +: REG_W] = srcs_i[k*REG_W +: REG_W] + soff;
            else if (mac && (SRC_CNT_W'(k) == cnt_i))
                ops_o.srcs[k*REG_W +: REG_W] = dst_step;
            else
                ops_o.srcs[k*REG_W +: REG_W] = '0;
        end
    end

    assign ops_o.dst     = dst_step;
    assign ops_o.src_cnt = mac ? cnt_i + 1'b1 : cnt_i;
endmodule

// File: rtl/vuop_seq.sv
module vuop_seq
    import vuop_pkg::*;
#(
    parameter int VREG_BYTES = 16,
    parameter int VL_W       = 8,
    parameter int CNT_W      = 16,
    localparam int UIDX_W    = VL_W + 2,
    localparam int SRC_BUS_W = MAX_SRC * REG_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 flush,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [2:0]           in_mode,
    input  logic [1:0]           in_sew,
    input  logic [VL_W-1:0]      in_vl,
    input  logic [VL_W-1:0]      in_vlmax,
    input  logic                 in_ta,
    input  logic [SRC_CNT_W-1:0] in_src_cnt,
    input  logic [SRC_BUS_W-1:0] in_srcs,
    input  logic [REG_W-1:0]     in_dst,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [UIDX_W-1:0]    out_idx,
    output logic [SRC_BUS_W-1:0] out_srcs,
    output logic [SRC_CNT_W-1:0] out_src_cnt,
    output logic [REG_W-1:0]     out_dst,
    output logic                 out_tail,
    output logic                 out_ta,
    output logic                 out_last,
    output logic                 err,
    output logic [CNT_W-1:0]     uop_count
);
    localparam int LOG_EPU0 = $clog2(VREG_BYTES);
    localparam int SPAN_W   = UIDX_W + LOG_EPU0 + 1;

    logic                 busy_q;
    logic [UIDX_W-1:0]    idx_q, total_q;
    logic [2:0]           mode_q;
    logic [ELOG_W-1:0]    elog_q;
    logic [VL_W-1:0]      vl_q;
    logic                 ta_q;
    logic [SRC_CNT_W-1:0] cnt_q;
    logic [SRC_BUS_W-1:0] srcs_q;
    logic [REG_W-1:0]     dst_q;
    logic                 err_q;
    logic [CNT_W-1:0]     count_q;

    logic [ELOG_W-1:0]    plan_elog;
    logic [UIDX_W-1:0]    plan_total;
    logic                 plan_bad;
    uop_ops_t             ops;
    logic                 take_in, take_out, last_now;
    logic [SPAN_W-1:0]    span;

    vuop_plan #(.VREG_BYTES(VREG_BYTES), .VL_W(VL_W)) u_plan (
        .mode(in_mode), .sew(in_sew), .vlmax(in_vlmax), .src_cnt(in_src_cnt),
        .elog(plan_elog), .total(plan_total), .bad(plan_bad)
    );

    vuop_operands u_ops (
        .mode(mode_q), .idx_lo(idx_q[REG_W-1:0]), .srcs_i(srcs_q),
        .cnt_i(cnt_q), .dst_i(dst_q), .ops_o(ops)
    );

    always_comb begin
        in_ready  = !busy_q && !flush;
        out_valid = busy_q && !flush;
        take_in   = in_valid && in_ready;
        take_out  = out_valid && out_ready;
        last_now  = (idx_q == total_q - 1'b1);
        span      = SPAN_W'(idx_q + 1'b1) << elog_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            idx_q   <= '0;
            total_q <= '0;
            mode_q  <= '0;
            elog_q  <= '0;
            vl_q    <= '0;
            ta_q    <= 1'b0;
            cnt_q   <= '0;
            srcs_q  <= '0;
            dst_q   <= '0;
            err_q   <= 1'b0;
            count_q <= '0;
        end else begin
            err_q <= take_in && plan_bad;
            if (flush) begin
                busy_q <= 1'b0;
                idx_q  <= '0;
            end else if (take_in && !plan_bad) begin
                busy_q  <= 1'b1;
                idx_q   <= '0;
                total_q <= plan_total;
                mode_q  <= in_mode;
                elog_q  <= plan_elog;
                vl_q    <= in_vl;
                ta_q    <= in_ta;
                cnt_q   <= in_src_cnt;
                srcs_q  <= in_srcs;
                dst_q   <= in_dst;
            end else if (take_out) begin
                if (last_now) begin
                    busy_q <= 1'b0;
                    idx_q  <= '0;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
            if (take_out && (count_q != '1))
                count_q <= count_q + 1'b1;
        end
    end

    assign out_idx     = idx_q;
    assign out_srcs    = ops.srcs;
    assign out_src_cnt = ops.src_cnt;
    assign out_dst     = ops.dst;
    assign out_tail    = span > SPAN_W'(vl_q);
    assign out_ta      = ta_q;
    assign out_last    = last_now;
    assign err         = err_q;
    assign uop_count   = count_q;
endmodule

// File: rtl/vuop_seq_chk.sv
module vuop_seq_chk #(
    parameter int VL_W  = 8,
    parameter int CNT_W = 16,
    localparam int UIDX_W = VL_W + 2
) (
    input logic              clk,
    input logic              rst,
    input logic              flush,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [UIDX_W-1:0] out_idx,
    input logic [4:0]        out_dst,
    input logic              out_last,
    input logic              err,
    input logic [CNT_W-1:0]  uop_count
);
    p_ready_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !(in_ready && out_valid));

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && !flush) |=>
        (flush || (out_valid && $stable(out_idx) && $stable(out_dst))));

    p_finish_r1: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> !out_valid);

    p_step_r1: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && !out_last) |=>
        (flush || (out_valid && (out_idx == $past(out_idx) + 1'b1))));

    p_flush_end_r10: assert property (@(posedge clk) disable iff (rst)
        flush |=> !out_valid);

    p_err_idle_r9: assert property (@(posedge clk) disable iff (rst)
        err |-> !out_valid);

    p_count_inc_r11: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && (uop_count != '1)) |=>
        (uop_count == $past(uop_count) + 1'b1));

    p_count_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && out_ready) |=> $stable(uop_count));
endmodule

bind vuop_seq vuop_seq_chk #(.VL_W(VL_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .flush(flush), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_idx(out_idx),
    .out_dst(out_dst), .out_last(out_last), .err(err), .uop_count(uop_count)
);

// File: tb/vuop_seq_tb.sv
module vuop_seq_tb;
    localparam int VL_W   = 8;
    localparam int CNT_W  = 6;
    localparam int VB     = 16;
    localparam int UIDX_W = VL_W + 2;
    localparam int CMAX   = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic flush = 1'b0, in_valid = 1'b0, in_ready, in_ta = 1'b0;
    logic [2:0] in_mode = '0, in_src_cnt = '0, out_src_cnt;
    logic [1:0] in_sew = '0;
    logic [VL_W-1:0] in_vl = '0, in_vlmax = '0;
    logic [19:0] in_srcs = '0, out_srcs;
    logic [4:0] in_dst = '0, out_dst;
    logic out_valid, out_ready = 1'b1, out_tail, out_ta, out_last, err;
    logic [UIDX_W-1:0] out_idx;
    logic [CNT_W-1:0] uop_count;

    vuop_seq #(.VREG_BYTES(VB), .VL_W(VL_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .flush(flush), .in_valid(in_valid), .in_ready(in_ready),
        .in_mode(in_mode), .in_sew(in_sew), .in_vl(in_vl), .in_vlmax(in_vlmax),
        .in_ta(in_ta), .in_src_cnt(in_src_cnt), .in_srcs(in_srcs), .in_dst(in_dst),
        .out_valid(out_valid), .out_ready(out_ready), .out_idx(out_idx),
        .out_srcs(out_srcs), .out_src_cnt(out_src_cnt), .out_dst(out_dst),
        .out_tail(out_tail), .out_ta(out_ta), .out_last(out_last), .err(err),
        .uop_count(uop_count)
    );

    always #4 clk = ~clk;

    typedef struct {
        int idx; int dst; int cnt; logic [19:0] srcs;
        bit tail; bit last; bit ta; int mode;
    } uop_t;

    uop_t q[$];
    int checks = 0, failures = 0, exp_cnt = 0, cyc = 0;
    bit exp_err = 1'b0, rmode = 1'b0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic string mtag(int m);
        case (m)
            2: return "R5";
            3: return "R4";
            4, 5: return "R6";
            default: return "R3";
        endcase
    endfunction

    task automatic model_accept(int m, int sew, int vl, int vlmax, bit ta,
                                int cnt, logic [19:0] s, int d);
        int epu = VB >> sew;
        int n = (vlmax + epu - 1) / epu;
        bit wide = (m == 3) || (m == 5);
        bit mac = (m == 4) || (m == 5);
        if (m < 1 || m > 5 || n == 0 || cnt > 4 || (mac && cnt == 4)) begin
            exp_err = 1'b1;
            return;
        end
        if (wide) n = n * 2;
        for (int i = 0; i < n; i++) begin
            uop_t u;
            int soff = wide ? (i / 2) * 2 : i;
            u.idx = i; u.mode = m; u.ta = ta;
            u.dst = (m == 2) ? d : (d + i) % 32;
            u.srcs = '0;
            for (int k = 0; k < cnt; k++)
                u.srcs[5*k +: 5] = 5'((int'(s[5*k +: 5]) + soff) % 32);
            if (mac) u.srcs[5*cnt +: 5] = 5'(u.dst);
            u.cnt = mac ? cnt + 1 : cnt;
            u.tail = (epu * (i + 1)) > vl;
            u.last = (i == n - 1);
            q.push_back(u);
        end
    endtask

    task automatic step();
        bit exp_rdy, exp_v, hs, acc, fl;
        out_ready = rmode ? cyc[0] : 1'b1;
        cyc++;
        #1;
        exp_rdy = (q.size() == 0) && !flush;
        exp_v = (q.size() > 0) && !flush;
        chk(in_ready == exp_rdy, flush ? "R10" : "R8", "in_ready", in_ready, exp_rdy);
        chk(out_valid == exp_v, flush ? "R10" : "R8", "out_valid", out_valid, exp_v);
        if (exp_v && out_valid) begin
            uop_t u = q[0];
            string lt = (u.mode == 3 || u.mode == 5) ? "R2" : "R1";
            chk(int'(out_idx) == u.idx, "R1", "out_idx", out_idx, u.idx);
            chk(out_last == u.last, lt, "out_last", out_last, u.last);
            chk(int'(out_dst) == u.dst, mtag(u.mode), "out_dst", out_dst, u.dst);
            chk(out_srcs == u.srcs, mtag(u.mode), "out_srcs", out_srcs, u.srcs);
            chk(int'(out_src_cnt) == u.cnt, "R6", "out_src_cnt", out_src_cnt, u.cnt);
            chk(out_tail == u.tail, "R7", "out_tail", out_tail, u.tail);
            chk(out_ta == u.ta, "R12", "out_ta", out_ta, u.ta);
        end
        chk(err == exp_err, "R9", "err", err, exp_err);
        chk(int'(uop_count) == exp_cnt, "R11", "uop_count", uop_count, exp_cnt);
        hs = exp_v && out_ready;
        acc = in_valid && exp_rdy;
        fl = flush;
        @(posedge clk);
        exp_err = 1'b0;
        if (fl) q.delete();
        else if (hs) void'(q.pop_front());
        if (hs && exp_cnt < CMAX) exp_cnt++;
        if (acc) model_accept(in_mode, in_sew, in_vl, in_vlmax, in_ta,
                              in_src_cnt, in_srcs, in_dst);
        @(negedge clk);
    endtask

    task automatic offer(int m, int sew, int vl, int vlmax, bit ta,
                         int cnt, logic [19:0] s, int d);
        in_mode = 3'(m); in_sew = 2'(sew); in_vl = VL_W'(vl); in_vlmax = VL_W'(vlmax);
        in_ta = ta; in_src_cnt = 3'(cnt); in_srcs = s; in_dst = 5'(d);
        in_valid = 1'b1;
        forever begin
            bit a = (q.size() == 0) && !flush;
            step();
            if (a) break;
        end
        in_valid = 1'b0;
    endtask

    task automatic drain();
        while (q.size() > 0) step();
        step();
    endtask

    function automatic logic [19:0] pack(int a, int b, int c, int e);
        return {5'(e), 5'(c), 5'(b), 5'(a)};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL R8 watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        step();                                            // reset state R8 R11
        offer(1, 0, 64, 64, 1'b0, 2, pack(4, 8, 0, 0), 12); drain();   // R1 R3
        offer(1, 0, 40, 64, 1'b1, 2, pack(4, 8, 0, 0), 12); drain();   // R7 R12
        offer(3, 1, 16, 16, 1'b0, 2, pack(2, 6, 0, 0), 20); drain();   // R2 R4
        offer(2, 2, 8, 8, 1'b0, 2, pack(1, 9, 0, 0), 3); drain();      // R5
        rmode = 1'b1;
        offer(4, 1, 24, 32, 1'b0, 2, pack(7, 11, 0, 0), 16);           // R6, backpressure R8
        offer(5, 2, 8, 8, 1'b1, 3, pack(5, 6, 7, 0), 24); drain();     // held offer while busy R8
        rmode = 1'b0;
        offer(3, 3, 5, 5, 1'b0, 1, pack(30, 0, 0, 0), 31); drain();    // ceil, tail R1 R7
        offer(1, 1, 32, 32, 1'b0, 4, pack(29, 30, 31, 1), 30); drain(); // wrap R3
        offer(4, 0, 16, 16, 1'b0, 4, pack(1, 2, 3, 4), 5); drain();    // overflow R9
        offer(0, 0, 16, 16, 1'b0, 1, pack(1, 0, 0, 0), 5); drain();    // none R9
        offer(7, 0, 16, 16, 1'b0, 1, pack(1, 0, 0, 0), 5); drain();    // unknown R9
        offer(1, 0, 0, 0, 1'b0, 1, pack(1, 0, 0, 0), 5); drain();      // zero count R9
        // flush mid sequence R10
        offer(1, 0, 64, 64, 1'b0, 1, pack(2, 0, 0, 0), 8);
        step();
        flush = 1'b1; in_valid = 1'b1; in_mode = 3'd1;
        step();
        flush = 1'b0; in_valid = 1'b0;
        step(); step();
        offer(2, 0, 32, 32, 1'b0, 1, pack(2, 0, 0, 0), 8); drain();    // after flush R10
        // saturation R11
        offer(1, 3, 128, 128, 1'b0, 1, pack(0, 0, 0, 0), 0); drain();
        offer(1, 0, 32, 32, 1'b0, 1, pack(0, 0, 0, 0), 0); drain();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule